// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

The controller collects seventeen interrupt sources, latches each request into a pending register and gates it with a per-source enable mask and a global disable. It offers the highest-priority eligible source to the core together with that source's service address. Five sources are fixed core events: debug-monitor, reset, power-down, stack exception and monitor-kernel. Twelve user slots follow them, and peripheral request lines are steered into those slots through a programmable 4-bit priority field per peripheral.

The request to the core is a valid/ready handshake. `irq_valid` with `irq_id` and `irq_vec` offers a source, and the core accepts it by raising `irq_ready` in a cycle where `irq_valid` is high. The offer is not held stable: if a higher-priority source becomes pending, or the one offered is cleared, the offer changes. An acceptance always applies to the id shown in that same cycle, so the core can hold back with `irq_ready` low for as long as it likes and loses nothing, because requests stay pending. Each accepted source is pushed onto an in-service stack, and a one-cycle `rti` pulse pops it.

A nesting control selects between two service disciplines. With nesting on, a source is offered only when its priority is strictly higher than the source on top of the stack. With nesting off, nothing is offered while anything is in service.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the pending register, the mask register and the service depth are zero, `irq_valid` is low, and every peripheral priority field is unassigned.
- R2: Source ids run in priority order from highest to lowest: 0 debug-monitor, 1 reset, 2 power-down, 3 stack exception, 4 monitor-kernel, and 5+k for user slot k (k = 0..11). Among eligible sources, the lowest id is offered.
- R3: For an offered id k ≥ 1, `irq_vec` equals (k−1)·0x20, so it runs from 0x000 for reset to 0x1E0 for user slot 11. For id 0, `irq_novec` is 1 and `irq_vec` is 0.
- R4: Mask bit i enables source id i, and a source is eligible only when its bit is 1. Mask bits 0, 1 and 2 have no effect, so those sources are never masked.
- R5: While `glob_dis` is high, ids 2 to 16 are not eligible, and ids 0 and 1 are unaffected.
- R6: A rising edge on `core_req[i]` (i = 0..4 gives id i) sets pending bit i at the next clock edge. A request line held high does not set the bit again.
- R7: A software set write makes pending bits 1 for every 1 in `sw_set_bits` at the next clock edge. When a set and a clear for the same bit land in one cycle, the set wins.
- R8: A software clear write makes pending bits 0 for every 1 in `sw_clr_bits`.
- R9: The priority field of peripheral p is written with `prio_wr`. A field value v from 0 to 11 routes a rising edge of `periph_req[p]` to pending id 5+v. Values 12 to 15 leave that peripheral unassigned, and its edges are ignored.
- R10: Acceptance (`irq_valid` and `irq_ready` high together) clears the offered pending bit and raises `svc_depth` by one.
- R11: With `nest_en` high and a source in service, an eligible source is offered only if its id is lower than the id on top of the in-service stack.
- R12: With `nest_en` low, `irq_valid` stays low whenever `svc_depth` is nonzero.
- R13: An `rti` pulse with `svc_depth` nonzero lowers it by one and exposes the previously stacked source as the new top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 5 | Core event request lines, ids 0..4 |
| periph_req | input | NUM_PERIPH | Peripheral request lines |
| prio_wr | input | 1 | Write strobe for a peripheral priority field |
| prio_idx | input | PIDX_W | Peripheral index to write |
| prio_wdata | input | 4 | Priority field value |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 17 | New mask value |
| sw_set_wr | input | 1 | Software pending-set strobe |
| sw_set_bits | input | 17 | Bits to set |
| sw_clr_wr | input | 1 | Software pending-clear strobe |
| sw_clr_bits | input | 17 | Bits to clear |
| glob_dis | input | 1 | Global interrupt disable |
| nest_en | input | 1 | 1 = nested service, 0 = one at a time |
| irq_valid | output | 1 | A source is offered |
| irq_ready | input | 1 | Core accepts the offered source |
| irq_id | output | 5 | Offered source id |
| irq_vec | output | VEC_W | Service address of the offered source |
| irq_novec | output | 1 | Offered source has no service address |
| rti | input | 1 | Return from the current service |
| pend_o | output | 17 | Pending register |
| mask_o | output | 17 | Mask register |
| svc_depth | output | 5 | Number of sources in service |

## Verification
The bound assertions check the gating rules on every cycle: an offer is always for a pending source, obeys the mask and the global disable, is never made in one-at-a-time mode while a source is in service, and shows no address for id 0. They also check that the service depth steps up on acceptance and down on return. The vector table and the directed scenarios show the outcomes that depend on history: which source wins, the exact address, edge-only latching of held requests, the steering of peripheral fields into user slots, and the order in which pre-empted sources come back after nested returns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_CORE = 5;
  localparam int NUM_USR  = 12;
  localparam int NUM_SRC  = NUM_CORE + NUM_USR;
  localparam int ID_W     = $clog2(NUM_SRC);
  localparam int PRIO_W   = 4;
  localparam int DEPTH_W  = $clog2(NUM_SRC + 1);

  // ids that ignore the mask register: debug-monitor, reset, power-down
  localparam logic [NUM_SRC-1:0] MASK_EXEMPT = NUM_SRC'(3'b111);
  // ids that ignore the global disable: debug-monitor, reset
  localparam logic [NUM_SRC-1:0] GDIS_EXEMPT = NUM_SRC'(2'b11);

  typedef logic [ID_W-1:0]    irq_id_t;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_periph_map.sv
module irq_periph_map
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int PIDX_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prio_wr,
  input  logic [PIDX_W-1:0]     prio_idx,
  input  logic [PRIO_W-1:0]     prio_wdata,
  input  logic [NUM_PERIPH-1:0] periph_req,
  output logic [NUM_USR-1:0]    slot_pulse
);
  logic [PRIO_W-1:0]     fld [NUM_PERIPH];
  logic [NUM_PERIPH-1:0] req_q;
  logic [NUM_PERIPH-1:0] req_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      for (int p = 0; p < NUM_PERIPH; p++) fld[p] <= '1;
    end else begin
      req_q <= periph_req;
      if (prio_wr && (32'(prio_idx) < NUM_PERIPH))
        fld[prio_idx] <= prio_wdata;
    end
  end

  assign req_rise = periph_req & ~req_q;

  for (genvar u = 0; u < NUM_USR; u++) begin : g_slot
    always_comb begin
      slot_pulse[u] = 1'b0;
      for (int p = 0; p < NUM_PERIPH; p++)
        if (req_rise[p] && (fld[p] == PRIO_W'(u))) slot_pulse[u] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CORE-1:0] core_req,
  input  logic [NUM_USR-1:0]  usr_pulse,
  input  logic                sw_set_wr,
  input  src_vec_t            sw_set_bits,
  input  logic                sw_clr_wr,
  input  src_vec_t            sw_clr_bits,
  input  logic                ack,
  input  irq_id_t             ack_id,
  input  logic                mask_wr,
  input  src_vec_t            mask_wdata,
  output src_vec_t            pend_q,
  output src_vec_t            mask_q
);
  logic [NUM_CORE-1:0] core_q;
  src_vec_t            set_v;
  src_vec_t            clr_v;

  always_comb begin
    set_v = {usr_pulse, core_req & ~core_q};
    if (sw_set_wr) set_v = set_v | sw_set_bits;
    clr_v = '0;
    if (sw_clr_wr) clr_v = sw_clr_bits;
    if (ack) clr_v[ack_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      core_q <= core_req;
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (mask_wr) mask_q <= mask_wdata;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int VEC_W    = 24,
  parameter int VEC_STEP = 32
) (
  input  src_vec_t           pend,
  input  src_vec_t           mask,
  input  logic               gdis,
  input  logic               nest_en,
  input  logic               svc_empty,
  input  irq_id_t            top_id,
  output logic               valid,
  output irq_id_t            id,
  output logic [VEC_W-1:0]   vec,
  output logic               novec
);
  src_vec_t elig;
  logic     found;
  logic     admit;

  always_comb begin
    elig = pend & (mask | MASK_EXEMPT);
    if (gdis) elig = elig & GDIS_EXEMPT;
    found = 1'b0;
    id    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        id    = ID_W'(i);
      end
    end
  end

  assign admit = svc_empty || (nest_en && (id < top_id));
  assign valid = found && admit;
  assign novec = (id == '0);
  assign vec   = novec ? '0 : VEC_W'((32'(id) - 32'd1) * VEC_STEP);
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  irq_id_t            push_id,
  input  logic               pop,
  output logic [DEPTH_W-1:0] depth,
  output irq_id_t            top_id,
  output logic               empty
);
  irq_id_t stk [NUM_SRC];

  assign empty  = (depth == '0);
  assign top_id = empty ? '1 : stk[depth - DEPTH_W'(1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      for (int k = 0; k < NUM_SRC; k++) stk[k] <= '0;
    end else if (push && pop && !empty) begin
      stk[depth - DEPTH_W'(1)] <= push_id;
    end else if (push && (32'(depth) < NUM_SRC)) begin
      stk[depth] <= push_id;
      depth      <= depth + DEPTH_W'(1);
    end else if (pop && !empty) begin
      depth <= depth - DEPTH_W'(1);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int PIDX_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1,
  parameter int VEC_W      = 24,
  parameter int VEC_STEP   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4:0]            core_req,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic                  prio_wr,
  input  logic [PIDX_W-1:0]     prio_idx,
  input  logic [3:0]            prio_wdata,
  input  logic                  mask_wr,
  input  logic [16:0]           mask_wdata,
  input  logic                  sw_set_wr,
  input  logic [16:0]           sw_set_bits,
  input  logic                  sw_clr_wr,
  input  logic [16:0]           sw_clr_bits,
  input  logic                  glob_dis,
  input  logic                  nest_en,
  output logic                  irq_valid,
  input  logic                  irq_ready,
  output logic [4:0]            irq_id,
  output logic [VEC_W-1:0]      irq_vec,
  output logic                  irq_novec,
  input  logic                  rti,
  output logic [16:0]           pend_o,
  output logic [16:0]           mask_o,
  output logic [4:0]            svc_depth
);
  logic [NUM_USR-1:0] usr_pulse;
  logic               ack;
  logic               svc_empty;
  irq_id_t            top_id;

  assign ack = irq_valid && irq_ready;

  irq_periph_map #(.NUM_PERIPH(NUM_PERIPH), .PIDX_W(PIDX_W)) u_map (
    .clk(clk), .rst_n(rst_n), .prio_wr(prio_wr), .prio_idx(prio_idx),
    .prio_wdata(prio_wdata), .periph_req(periph_req), .slot_pulse(usr_pulse)
  );

  irq_pend_reg u_pend (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .usr_pulse(usr_pulse),
    .sw_set_wr(sw_set_wr), .sw_set_bits(sw_set_bits),
    .sw_clr_wr(sw_clr_wr), .sw_clr_bits(sw_clr_bits),
    .ack(ack), .ack_id(irq_id), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .pend_q(pend_o), .mask_q(mask_o)
  );

  irq_prio_enc #(.VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_enc (
    .pend(pend_o), .mask(mask_o), .gdis(glob_dis), .nest_en(nest_en),
    .svc_empty(svc_empty), .top_id(top_id), .valid(irq_valid), .id(irq_id),
    .vec(irq_vec), .novec(irq_novec)
  );

  irq_svc_stack u_stk (
    .clk(clk), .rst_n(rst_n), .push(ack), .push_id(irq_id), .pop(rti),
    .depth(svc_depth), .top_id(top_id), .empty(svc_empty)
  );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        glob_dis,
  input logic        nest_en,
  input logic        irq_valid,
  input logic        irq_ready,
  input logic [4:0]  irq_id,
  input logic        irq_novec,
  input logic        rti,
  input logic [16:0] pend_o,
  input logic [16:0] mask_o,
  input logic [4:0]  svc_depth
);
  AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_id < 5'd17) && pend_o[irq_id]); // R2
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_id >= 5'd3) |-> mask_o[irq_id]); // R4
  AST_GDIS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && glob_dis) |-> (irq_id < 5'd2)); // R5
  AST_NO_VEC_ID0: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_id == 5'd0) |-> irq_novec); // R3
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && svc_depth != 5'd0) |-> !irq_valid); // R12
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !rti && svc_depth < 5'd17) |=>
      (svc_depth == $past(svc_depth) + 5'd1)); // R10
  AST_RTI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && svc_depth != 5'd0 && !(irq_valid && irq_ready)) |=>
      (svc_depth == $past(svc_depth) - 5'd1)); // R13
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .glob_dis(glob_dis), .nest_en(nest_en),
  .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id),
  .irq_novec(irq_novec), .rti(rti), .pend_o(pend_o), .mask_o(mask_o),
  .svc_depth(svc_depth)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  core_req = '0;
  logic [NP-1:0] periph_req = '0;
  logic        prio_wr = 1'b0;
  logic [2:0]  prio_idx = '0;
  logic [3:0]  prio_wdata = '0;
  logic        mask_wr = 1'b0;
  logic [16:0] mask_wdata = '0;
  logic        sw_set_wr = 1'b0;
  logic [16:0] sw_set_bits = '0;
  logic        sw_clr_wr = 1'b0;
  logic [16:0] sw_clr_bits = '0;
  logic        glob_dis = 1'b0;
  logic        nest_en = 1'b1;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [4:0]  irq_id;
  logic [23:0] irq_vec;
  logic        irq_novec;
  logic        rti = 1'b0;
  logic [16:0] pend_o;
  logic [16:0] mask_o;
  logic [4:0]  svc_depth;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl #(.NUM_PERIPH(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .periph_req(periph_req),
    .prio_wr(prio_wr), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .sw_set_wr(sw_set_wr), .sw_set_bits(sw_set_bits),
    .sw_clr_wr(sw_clr_wr), .sw_clr_bits(sw_clr_bits),
    .glob_dis(glob_dis), .nest_en(nest_en), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_id(irq_id), .irq_vec(irq_vec),
    .irq_novec(irq_novec), .rti(rti), .pend_o(pend_o), .mask_o(mask_o),
    .svc_depth(svc_depth)
  );

  // {pending 17, mask 17, gdis 1, exp_valid 1, exp_id 5}
  localparam logic [40:0] TBL [10] = '{
    {17'h10000, 17'h00000, 1'b0, 1'b0, 5'd0},
    {17'h10000, 17'h10000, 1'b0, 1'b1, 5'd16},
    {17'h00220, 17'h1FFFF, 1'b0, 1'b1, 5'd5},
    {17'h00004, 17'h00000, 1'b0, 1'b1, 5'd2},
    {17'h00004, 17'h00000, 1'b1, 1'b0, 5'd0},
    {17'h00006, 17'h00000, 1'b1, 1'b1, 5'd1},
    {17'h00003, 17'h00000, 1'b0, 1'b1, 5'd0},
    {17'h00018, 17'h00010, 1'b0, 1'b1, 5'd4},
    {17'h1FFF8, 17'h1FFFF, 1'b1, 1'b0, 5'd0},
    {17'h01400, 17'h01000, 1'b0, 1'b1, 5'd12}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic accept();
    irq_ready = 1'b1;
    tick();
    irq_ready = 1'b0;
  endtask

  task automatic do_rti();
    rti = 1'b1;
    tick();
    rti = 1'b0;
  endtask

  task automatic sw_set(input logic [16:0] b);
    sw_set_wr = 1'b1; sw_set_bits = b;
    tick();
    sw_set_wr = 1'b0;
  endtask

  task automatic sw_clear_all();
    sw_clr_wr = 1'b1; sw_clr_bits = '1;
    tick();
    sw_clr_wr = 1'b0;
  endtask

  task automatic pulse_periph(input int p);
    periph_req[p] = 1'b1;
    tick();
    periph_req[p] = 1'b0;
  endtask

  function automatic logic [31:0] exp_vec(input logic [4:0] id);
    return (id == 5'd0) ? 32'd0 : (32'(id) - 32'd1) * 32'h20;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pend", 32'(pend_o), 32'd0);
    check("R1 mask", 32'(mask_o), 32'd0);
    check("R1 valid", 32'(irq_valid), 32'd0);
    check("R1 depth", 32'(svc_depth), 32'd0);
    // R1/R9 unassigned after reset: peripheral edge sets nothing
    pulse_periph(0);
    check("R1 periph unassigned", 32'(pend_o), 32'd0);

    // R2 R3 R4 R5 R7 table walk
    for (int t = 0; t < 10; t++) begin
      logic [16:0] tp;
      logic [16:0] tm;
      logic [4:0]  tid;
      tp  = TBL[t][40:24];
      tm  = TBL[t][23:7];
      tid = TBL[t][4:0];
      sw_clr_wr = 1'b1; sw_clr_bits = '1;
      sw_set_wr = 1'b1; sw_set_bits = tp;
      mask_wr = 1'b1; mask_wdata = tm;
      glob_dis = TBL[t][6];
      tick();
      sw_clr_wr = 1'b0; sw_set_wr = 1'b0; mask_wr = 1'b0;
      check("R7 pending set wins", 32'(pend_o), 32'(tp));
      check("R2 R4 R5 valid", 32'(irq_valid), 32'(TBL[t][5]));
      if (TBL[t][5]) begin
        check("R2 id", 32'(irq_id), 32'(tid));
        check("R3 vec", 32'(irq_vec), exp_vec(tid));
        check("R3 novec", 32'(irq_novec), 32'(tid == 5'd0));
      end
    end
    glob_dis = 1'b0;

    // R8 software clear
    sw_clr_wr = 1'b1; sw_clr_bits = 17'h01000;
    tick();
    sw_clr_wr = 1'b0;
    check("R8 clear", 32'(pend_o), 32'h00400);
    sw_clear_all();
    check("R8 clear all", 32'(pend_o), 32'd0);

    // R10 R11 R13 nesting
    mask_wr = 1'b1; mask_wdata = '1;
    tick();
    mask_wr = 1'b0;
    nest_en = 1'b1;
    sw_set(17'h00400);
    check("R10 offer 10", 32'(irq_id), 32'd10);
    accept();
    check("R10 depth 1", 32'(svc_depth), 32'd1);
    check("R10 pend cleared", 32'(pend_o), 32'd0);
    sw_set(17'h01000);
    check("R11 lower blocked", 32'(irq_valid), 32'd0);
    sw_set(17'h00080);
    check("R11 higher offered", 32'(irq_valid), 32'd1);
    check("R11 higher id", 32'(irq_id), 32'd7);
    accept();
    check("R10 depth 2", 32'(svc_depth), 32'd2);
    do_rti();
    check("R13 depth 1", 32'(svc_depth), 32'd1);
    check("R13 top is 10 again", 32'(irq_valid), 32'd0);
    do_rti();
    check("R13 depth 0", 32'(svc_depth), 32'd0);
    check("R13 id 12 offered", 32'(irq_id), 32'd12);
    accept();
    do_rti();
    check("R13 back to idle", 32'(svc_depth), 32'd0);

    // R12 sequential
    nest_en = 1'b0;
    sw_set(17'h04000);
    accept();
    sw_set(17'h00040);
    check("R12 held while busy", 32'(irq_valid), 32'd0);
    do_rti();
    check("R12 offered after return", 32'(irq_valid), 32'd1);
    check("R12 id", 32'(irq_id), 32'd6);
    accept();
    do_rti();
    nest_en = 1'b1;

    // R6 edge latching of core requests
    core_req[3] = 1'b1;
    tick();
    check("R6 edge sets pending", 32'(pend_o), 32'h00008);
    check("R6 vec stack", 32'(irq_vec), 32'h40);
    accept();
    tick();
    check("R6 held level no re-set", 32'(pend_o), 32'd0);
    do_rti();
    core_req[3] = 1'b0;

    // R9 peripheral steering
    prio_wr = 1'b1; prio_idx = 3'd2; prio_wdata = 4'd3;
    tick();
    prio_idx = 3'd1; prio_wdata = 4'd12;
    tick();
    prio_wr = 1'b0;
    pulse_periph(2);
    check("R9 field 3 to id 8", 32'(pend_o), 32'h00100);
    check("R9 vec", 32'(irq_vec), 32'hE0);
    sw_clear_all();
    pulse_periph(1);
    check("R9 field 12 ignored", 32'(pend_o), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule